// File: doc/BRIEF.md
# Dual Interval Timer Region With Identification Words

This block occupies a 4 KB register region and places two interval timers inside it. A single register port (address, write strobe, write data) reaches both timers: the low 32-byte window belongs to the first timer, the next 32-byte window to the second. An access to the second window reaches that timer with the window base removed, so both timers see the same local register layout.

The top 32 bytes of the region hold eight read-only identification words, each carrying one fixed byte in its low eight bits. Two integration-test words near the top read as zero and do nothing. Every other offset reads as zero, and writes that fall outside the two timer windows change nothing.

Each timer counts on its own tick-enable input, so the two can run at different rates. With the intended system wiring, both tick inputs pulse at 1 MHz. The interrupt requests of the two timers are merged into one output. Read data is captured into a register, so any read returns its word one clock after the address is presented.

Top module: `dual_timer_wrap`

## Requirements
- R1: Offsets 0x000–0x01F reach timer 0, and a write there leaves timer 1 unchanged.
- R2: Offsets 0x020–0x03F reach timer 1 at local offset (offset − 0x20), and a write there leaves timer 0 unchanged. Local layout: 0x00 reload value, 0x04 current count (read-only), 0x08 control (reset 0x20; bit7 run, bit6 periodic, bit5 interrupt enable, bit1 32-bit, bit0 single-shot), 0x0C interrupt clear, 0x10 raw interrupt, 0x14 masked interrupt, 0x18 reload value written without reloading the count.
- R3: Words 0xFE0, 0xFE4, …, 0xFFC read 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in bits 7:0, in rising address order, with bits 31:8 zero.
- R4: `irq` is high whenever either timer has a pending, enabled interrupt. Clearing one timer leaves `irq` high while the other is still pending.
- R5: Reads of 0xF00 and 0xF04 return zero, including after a write to them.
- R6: Writes to the identification words have no effect; they read back their fixed values.
- R7: All other offsets read zero, and writes outside the two timer windows change neither timer.
- R8: Each timer advances only on its own bit of `tick_i`; pulsing one tick bit leaves the other timer's count unchanged.
- R9: `rdata` presents the word addressed in cycle N at the rising edge that ends cycle N, so it is valid throughout cycle N+1, for timer and non-timer offsets alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 2 | Per-timer count enable, bit n for timer n |
| addr | input | 12 | Byte offset inside the region |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Merged interrupt request of both timers |

## Verification
Read results are due one rising edge after the address is applied. The bench drives the address at a falling edge and pushes the expected word into a queue at the same time. A monitor then pops and compares 1 ns after the following rising edge.

Interrupt and count effects of a write or a tick are due at the first rising edge that samples the strobe. The bench therefore checks `irq` at the falling edge that follows, and reads counts back through the normal one-cycle read path. The checker compares each registered read against the previous cycle's address, and ties every falling edge of `irq` to a write in the cycle before.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int ID_WORDS = 8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h04;
      3'd1: b = 8'h18;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dtw_id_rom.sv
module dtw_id_rom #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        idx,
  output logic [DATA_W-1:0] word_o
);
  always_comb word_o = DATA_W'(dtw_pkg::id_byte(idx));
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] MAX16 = DATA_W'(17'h0FFFF);
  localparam logic [DATA_W-1:0] MAX32 = '1;

  logic [DATA_W-1:0] reload_q, count_q, cmask;
  logic [7:0]        ctrl_q;
  logic [PRE_W-1:0]  pre_q;
  logic              pend_q, step;

  wire run  = ctrl_q[7];
  wire per  = ctrl_q[6];
  wire ien  = ctrl_q[5];
  wire [1:0] div = ctrl_q[3:2];
  wire wide = ctrl_q[1];
  wire once = ctrl_q[0];

  always_comb begin
    cmask = wide ? MAX32 : MAX16;
    case (div)
      2'd0:    step = tick & run;
      2'd1:    step = tick & run & (&pre_q[3:0]);
      default: step = tick & run & (&pre_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= MAX16;
      ctrl_q   <= 8'h20;
      pend_q   <= 1'b0;
      pre_q    <= '0;
    end else begin
      if (tick & run) pre_q <= pre_q + 1'b1;
      if (step) begin
        if (count_q == '0) begin
          pend_q <= 1'b1;
          if (once)     ctrl_q[7] <= 1'b0;
          else if (per) count_q <= reload_q & cmask;
          else          count_q <= cmask;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      if (wr_en) begin
        case (word)
          3'd0: begin reload_q <= wdata; count_q <= wdata & cmask; end
          3'd2: ctrl_q <= wdata[7:0];
          3'd3: pend_q <= 1'b0;
          3'd6: reload_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word)
      3'd0, 3'd6: rdata = reload_q;
      3'd1:       rdata = count_q;
      3'd2:       rdata = DATA_W'(ctrl_q);
      3'd4:       rdata = DATA_W'(pend_q);
      3'd5:       rdata = DATA_W'(pend_q & ien);
      default:    rdata = '0;
    endcase
  end

  assign irq = pend_q & ien;
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int N_TMR   = 2,
  parameter int WIN_LG2 = 5,
  parameter int ID_BASE = 'hFE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TMR-1:0]  tick_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - WIN_LG2;
  localparam logic [SEL_W-1:0] ID_SEL = SEL_W'(ID_BASE >> WIN_LG2);

  logic [SEL_W-1:0]  win;
  logic [DATA_W-1:0] t_rdata [N_TMR];
  logic [N_TMR-1:0]  t_irq;
  logic [DATA_W-1:0] id_word, rd_mux;

  assign win = addr[ADDR_W-1:WIN_LG2];

  for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
    dtw_timer #(.DATA_W(DATA_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick_i[n]),
      .wr_en (wr_en && (win == SEL_W'(n))),
      .word  (addr[4:2]),
      .wdata (wdata),
      .rdata (t_rdata[n]),
      .irq   (t_irq[n])
    );
  end

  dtw_id_rom #(.DATA_W(DATA_W)) u_id (
    .idx    (addr[4:2]),
    .word_o (id_word)
  );

  always_comb begin
    rd_mux = '0;
    if (win == ID_SEL) rd_mux = id_word;
    for (int n = 0; n < N_TMR; n++)
      if (win == SEL_W'(n)) rd_mux = t_rdata[n];
  end

  always_ff @(posedge clk) rdata <= rd_mux;

  assign irq = |t_irq;
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_TMR  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_TMR-1:0]  tick_i,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);
  function automatic logic [DATA_W-1:0] want_id(input logic [2:0] i);
    logic [7:0] v;
    case (i)
      3'd0: v = 8'h04; 3'd1: v = 8'h18; 3'd2: v = 8'h14; 3'd3: v = 8'h00;
      3'd4: v = 8'h0D; 3'd5: v = 8'hF0; 3'd6: v = 8'h05; default: v = 8'hB1;
    endcase
    return DATA_W'(v);
  endfunction

  wire id_hit   = addr >= ADDR_W'('hFE0);
  wire test_hit = (addr == ADDR_W'('hF00)) || (addr == ADDR_W'('hF04));
  wire hole_hit = (addr >= ADDR_W'('h40)) && !id_hit;

  p_id_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(id_hit)) |-> rdata == want_id($past(addr[4:2])));

  p_test_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_hit)) |-> rdata == '0);

  p_hole_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hole_hit)) |-> rdata == '0);

  p_irq_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_en));

  p_ignored_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && hole_hit && tick_i == '0)) |-> irq == $past(irq));
endmodule

bind dual_timer_wrap dtw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_TMR(N_TMR)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .addr(addr),
  .wr_en(wr_en), .rdata(rdata), .irq(irq)
);

// File: tb/dual_timer_wrap_tb_top.sv
`timescale 1ns/1ps
module dual_timer_wrap_tb_top;
  logic        clk = 0, rst = 1, wr_en = 0;
  logic [1:0]  tick_i = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int tests = 0, fails = 0;
  logic        armed = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dual_timer_wrap dut_i (.clk(clk), .rst(rst), .tick_i(tick_i), .addr(addr),
                         .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: present address, push expectation (R9: due one edge later)
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; armed = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (armed) begin
      armed = 0;
      chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tk(input int n, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); tick_i[n] = 1;
      @(negedge clk); tick_i[n] = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R4 reset irq", {31'b0, irq}, 0);
    rd(12'h008, 32'h20, "R1 t0 control reset");
    rd(12'h028, 32'h20, "R2 t1 control reset");
    // R1/R2 decode and offset translation
    wr(12'h000, 32'h1234);
    rd(12'h000, 32'h1234, "R1 t0 reload");
    rd(12'h020, 32'h0, "R1 t1 untouched");
    wr(12'h020, 32'hABCD);
    rd(12'h020, 32'hABCD, "R2 t1 reload");
    rd(12'h024, 32'hABCD, "R2 t1 count");
    rd(12'h000, 32'h1234, "R2 t0 untouched");
    // R3 identification words
    begin
      logic [7:0] ids [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++)
        rd(12'hFE0 + 12'(i * 4), {24'b0, ids[i]}, "R3 id word");
    end
    // R5 test words
    wr(12'hF00, 32'hFFFF_FFFF);
    wr(12'hF04, 32'h5A5A_5A5A);
    rd(12'hF00, 0, "R5 test word 0");
    rd(12'hF04, 0, "R5 test word 1");
    // R6 id write ignored
    wr(12'hFE4, 32'h0000_00EE);
    rd(12'hFE4, 32'h18, "R6 id after write");
    // R7 holes
    wr(12'h040, 32'hDEAD);
    wr(12'h100, 32'hBEEF);
    rd(12'h040, 0, "R7 hole 0x040");
    rd(12'h100, 0, "R7 hole 0x100");
    rd(12'hFDC, 0, "R7 hole 0xFDC");
    rd(12'h000, 32'h1234, "R7 t0 reload after hole writes");
    rd(12'h020, 32'hABCD, "R7 t1 reload after hole writes");
    // R4/R8 interrupts and independent ticks
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE2);
    tk(0, 4);
    chk("R4 irq from t0", {31'b0, irq}, 1);
    rd(12'h010, 1, "R4 t0 raw pending");
    rd(12'h024, 32'hABCD, "R8 t1 count unchanged by tick0");
    wr(12'h00C, 0);
    chk("R4 irq cleared", {31'b0, irq}, 0);
    tk(0, 1);
    rd(12'h004, 32'd2, "R8 t0 count after 5 ticks");
    wr(12'h020, 32'd2);
    wr(12'h028, 32'hE2);
    tk(1, 3);
    chk("R4 irq from t1", {31'b0, irq}, 1);
    rd(12'h004, 32'd2, "R8 t0 count unchanged by tick1");
    tk(0, 3);
    wr(12'h02C, 0);
    chk("R4 irq held by t0", {31'b0, irq}, 1);
    rd(12'h034, 0, "R4 t1 masked cleared");
    wr(12'h00C, 0);
    chk("R4 irq both clear", {31'b0, irq}, 0);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule